// File: doc/BRIEF.md
# Video Presence Detector with Internal Fallback

This block watches a stream of 8-bit level samples taken from an external video input and decides whether a real signal is there. Whenever a valid sample rises above a fixed level threshold, the block treats the external source as live: it turns off the internal sync/picture generator and opens the output switch, so internally made video cannot feed back onto the external line.

A free-running timeout counter is cleared by every above-threshold sample. If it runs a full period without being cleared, the block concludes that the external source is gone. It then enables the internal generator and closes the switch so the internal picture reaches the output. The default period is 65,536 clock cycles, which is about 3.3 ms, or roughly 51 video lines, at 20 MHz. The counter wraps and keeps running, so a long silence keeps re-confirming the fallback. The period is a parameter, so simulations can use a short one.

Top module: `vpd_presence_det`

## Requirements
- R1: While reset is asserted, and after it is released until the first detection, `gen_en_o` = 1 and `sw_close_o` = 1 (internal video selected).
- R2: A sample with `sample_vld_i` = 1 and value strictly greater than `THRESH` (default 20) drives `gen_en_o` = 0 and `sw_close_o` = 0 on the next clock edge.
- R3: A valid sample with value at or below `THRESH` (including exactly 20) leaves both outputs unchanged and does not restart the timeout window.
- R4: When `sample_vld_i` = 0, the value on `sample_i` has no effect on the outputs or the timeout window, whatever that value is.
- R5: After the last above-threshold sample, the outputs stay at 0 for `TIMEOUT_CYCLES` − 1 further edges and both become 1 at edge number `TIMEOUT_CYCLES` after it.
- R6: Each above-threshold sample restarts the full `TIMEOUT_CYCLES` window.
- R7: `sw_close_o` equals `gen_en_o` in every cycle.
- R8: Once back in internal mode, continued absence of signal keeps both outputs at 1 across further counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_i | input | 8 | Level sample of the external video input (`SAMPLE_W` bits) |
| sample_vld_i | input | 1 | Qualifies `sample_i` for one cycle |
| gen_en_o | output | 1 | 1 = internal sync/picture generator enabled |
| sw_close_o | output | 1 | 1 = output switch closed, internal video passes |

## Verification
The assertions treat any cycle without a qualified above-threshold sample as quiet. They also assume that a sample presented while the internal reset is still held has no effect, so they are measured from the synchronized reset release. The stimulus respects this: it keeps `sample_vld_i` low until several cycles after reset release. After that it mixes mostly below-threshold values with sparse above-threshold ones, so gaps fall on both sides of the timeout. Directed cases cover the exact threshold value, invalid high-valued samples, a restart just before expiry, and long silences across several wraps.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

  // Who owns the video output.
  typedef enum logic {
    MODE_INTERNAL = 1'b0,
    MODE_EXTERNAL = 1'b1
  } vpd_mode_e;

  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/vpd_rst_sync.sv
module vpd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/vpd_level_cmp.sv
module vpd_level_cmp #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned THRESH   = 20
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_vld_i,
  output logic                hit_o
);

  localparam logic [SAMPLE_W-1:0] THR = SAMPLE_W'(THRESH);

  logic above;

  always_comb begin
    above = (sample_i > THR);
    hit_o = sample_vld_i & above;
  end

endmodule

// File: rtl/vpd_timeout.sv
module vpd_timeout #(
  parameter int unsigned TIMEOUT_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic expire_o
);

  localparam int unsigned CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_last;

  always_comb begin
    at_last  = (cnt_q == LAST);
    expire_o = at_last & ~clr_i;
    if (clr_i || at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/vpd_mode_ctrl.sv
module vpd_mode_ctrl
  import vpd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic expire_i,
  output logic gen_en_o,
  output logic sw_close_o
);

  vpd_mode_e mode_q;
  vpd_mode_e mode_d;
  logic      mode_en;

  always_comb begin
    mode_en = hit_i | expire_i;
    mode_d  = hit_i ? MODE_EXTERNAL : MODE_INTERNAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INTERNAL;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign gen_en_o   = (mode_q == MODE_INTERNAL);
  assign sw_close_o = (mode_q == MODE_INTERNAL);

endmodule

// File: rtl/vpd_presence_det.sv
module vpd_presence_det
  import vpd_pkg::*;
#(
  parameter int unsigned SAMPLE_W       = 8,
  parameter int unsigned THRESH         = 20,
  parameter int unsigned TIMEOUT_CYCLES = 65536
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_vld_i,
  output logic                gen_en_o,
  output logic                sw_close_o
);

  logic rst_sync_n;
  logic hit;
  logic expire;

  vpd_rst_sync #(
    .STAGES(RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  vpd_level_cmp #(
    .SAMPLE_W(SAMPLE_W),
    .THRESH  (THRESH)
  ) u_level_cmp (
    .sample_i    (sample_i),
    .sample_vld_i(sample_vld_i),
    .hit_o       (hit)
  );

  vpd_timeout #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_timeout (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (hit),
    .expire_o(expire)
  );

  vpd_mode_ctrl u_mode_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hit_i     (hit),
    .expire_i  (expire),
    .gen_en_o  (gen_en_o),
    .sw_close_o(sw_close_o)
  );

endmodule

// File: rtl/vpd_presence_det_chk.sv
module vpd_presence_det_chk #(
  parameter int unsigned SAMPLE_W       = 8,
  parameter int unsigned THRESH         = 20,
  parameter int unsigned TIMEOUT_CYCLES = 65536
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic                sample_vld_i,
  input logic                gen_en_o,
  input logic                sw_close_o
);

  localparam int unsigned CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic             live;
  logic [CNT_W-1:0] quiet_q;

  assign live = sample_vld_i && (sample_i > SAMPLE_W'(THRESH));

  // Independent count of quiet cycles since the last qualified sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
    end else if (live || quiet_q == LAST) begin
      quiet_q <= '0;
    end else begin
      quiet_q <= quiet_q + CNT_W'(1);
    end
  end

  p_reset_internal_r1: assert property (@(posedge clk)
    !rst_n |-> (gen_en_o && sw_close_o));

  p_live_external_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> (!gen_en_o && !sw_close_o));

  // R3 and R4: a quiet cycle before the window closes changes nothing.
  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && quiet_q != LAST) |=> $stable(gen_en_o));

  p_expire_internal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && quiet_q == LAST) |=> (gen_en_o && sw_close_o));

  p_internal_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && gen_en_o) |=> gen_en_o);

endmodule

bind vpd_presence_det vpd_presence_det_chk #(
  .SAMPLE_W      (SAMPLE_W),
  .THRESH        (THRESH),
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .sample_i    (sample_i),
  .sample_vld_i(sample_vld_i),
  .gen_en_o    (gen_en_o),
  .sw_close_o  (sw_close_o)
);

// File: tb/vpd_presence_det_tb.sv
module vpd_presence_det_tb;

  localparam int TO = 40;
  localparam int TH = 20;

  logic       clk;
  logic       rst_n;
  logic [7:0] sample;
  logic       vld;
  logic       gen_en;
  logic       sw_close;

  int n_checks;
  int n_fail;
  bit done;
  bit model_on;
  bit m_ext;
  int m_quiet;

  vpd_presence_det #(
    .SAMPLE_W      (8),
    .THRESH        (TH),
    .TIMEOUT_CYCLES(TO)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_i    (sample),
    .sample_vld_i(vld),
    .gen_en_o    (gen_en),
    .sw_close_o  (sw_close)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit is_live(input bit v, input logic [7:0] s);
    return v && (int'(s) > TH);
  endfunction

  // Reference behaviour from the requirements.
  always @(posedge clk) begin
    if (model_on) begin
      if (is_live(vld, sample)) begin
        m_ext   = 1'b1;
        m_quiet = 0;
      end else begin
        m_quiet = m_quiet + 1;
        if (m_quiet == TO) begin
          m_ext   = 1'b0;
          m_quiet = 0;
        end
      end
    end
  end

  task automatic check(input string tag, input bit exp_gen);
    n_checks++;
    if (gen_en !== exp_gen || sw_close !== exp_gen) begin
      n_fail++;
      $display("FAIL %s: gen_en=%0b sw_close=%0b expected %0b/%0b",
               tag, gen_en, sw_close, exp_gen, exp_gen);
    end
  endtask

  task automatic check_r7();
    n_checks++;
    if (gen_en !== sw_close) begin
      n_fail++;
      $display("FAIL R7: gen_en=%0b sw_close=%0b expected equal", gen_en, sw_close);
    end
  endtask

  // Called at a negedge: drive, wait to the next negedge, compare.
  task automatic cyc(input bit v, input logic [7:0] s, input string tag);
    vld    = v;
    sample = s;
    @(negedge clk);
    check(tag, !m_ext);
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    n_checks = 0; n_fail = 0; done = 0;
    model_on = 0; m_ext = 0; m_quiet = 0;
    rst_n = 1'b0; vld = 1'b0; sample = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release", 1'b1);
    model_on = 1;

    // R3: exactly the threshold does not count.
    cyc(1'b1, 8'd20, "R3 value 20");
    // R4: invalid high value ignored in internal mode.
    cyc(1'b0, 8'd255, "R4 invalid 255 internal");
    // R2: just above threshold.
    cyc(1'b1, 8'd21, "R2 value 21");
    check_r7();
    // R5: window length after a detection.
    quiet(TO - 1, "R5 before expiry");
    cyc(1'b0, 8'd0, "R5 at expiry");
    check_r7();
    // R8: long silence across wraps.
    quiet(2 * TO + 3, "R8 stays internal");

    // R4: invalid high values do not restart the window.
    cyc(1'b1, 8'd255, "R2 value 255");
    for (int i = 0; i < TO - 1; i++) cyc(1'b0, 8'd200, "R4 invalid in window");
    cyc(1'b0, 8'd200, "R4 expiry not delayed");

    // R3: valid low samples do not restart the window.
    cyc(1'b1, 8'd100, "R2 value 100");
    for (int i = 0; i < TO - 1; i++) cyc(1'b1, 8'(i % 21), "R3 low in window");
    cyc(1'b1, 8'd20, "R3 expiry not delayed");

    // R6: restart just before expiry.
    cyc(1'b1, 8'd50, "R2 start window");
    quiet(TO - 2, "R6 first window");
    cyc(1'b1, 8'd22, "R6 restart");
    quiet(TO - 1, "R6 second window");
    cyc(1'b0, 8'd0, "R6 expiry after restart");

    // Random mix: sparse live samples, gaps around the timeout.
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      bit v;
      logic [7:0] s;
      r = $urandom % 100;
      v = (r < 50);
      s = (r < 3) ? 8'(21 + ($urandom % 235)) : 8'($urandom % 21);
      if (r >= 50 && ($urandom % 4) == 0) s = 8'($urandom % 256);
      cyc(v, s, "R6 random");
      check_r7();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule